// File: doc/BRIEF.md
# E1 Channel Timeslot Drop and Insert

This block sits on a frame-aligned 2048 kbit/s composite stream. The stream arrives one bit per enabled cycle, and a frame-start marker flags the first bit of each 256-bit frame. The block has a parameterised number of tributary ports, four by default. Each port can own one 64 kbit/s channel timeslot. During that slot the port drops the incoming octet to a byte-wide output. In the same slot of the outgoing composite it inserts the port's tributary octet, a pass-through of the original data, or an all-ones alarm pattern.

Only the payload slots 1 to 15 and 17 to 31 can be assigned. The framing slot 0 and the signalling slot 16 always pass through untouched, as does any slot that no port owns. The block resolves assignments in one of two ways. In explicit mode each port has its own slot register. In default mode the ports take payload slots in a fixed interleaved priority sequence. An invalid or clashing assignment is refused and flagged. New assignments are taken only at frame start, so a frame is never split across two configurations.

Top module: `tsx_drop_insert`

## Requirements
- R1: `out_en` equals `in_en` delayed by one clock. For an enabled bit in a slot that no active port owns, including slots 0 and 16, `out_bit` one clock later equals `in_bit`.
- R2: An active port captures the 8 bits of its slot, first-received bit in bit 7 of `drop_data`. `drop_valid` for that port is high for exactly one clock, in the same cycle that `out_en` reflects the slot's last bit. `drop_data` holds its value otherwise. Dropping happens whether insertion is inhibited or alarmed or not.
- R3: With neither inhibit nor alarm in force, the slot's output bits carry the port's `trib_data` octet, bit 7 first. The octet is sampled at the slot's first bit, so later changes to `trib_data` within the slot do not affect the output.
- R4: When `ins_inhibit` is high at the slot's first bit, the whole slot passes `in_bit` to `out_bit` unchanged.
- R5: When `ins_ais` is high at the slot's first bit, every output bit of that slot is 1. This holds even if `ins_inhibit` is also high.
- R6: An enabled port whose slot field is 0 or 16 is refused. Its `cfg_err` bit is set, it never pulses `drop_valid`, and it inserts nothing.
- R7: When two enabled ports select the same slot, the lower-indexed port keeps it. The higher-indexed port is refused and flagged in `cfg_err`.
- R8: With `cfg_dflt` high, `cfg_slot` and `cfg_en` are ignored, all ports are active, and port k owns the k-th slot of the sequence 6, 22, 14, 30, 2, 18, 10, 26, 4, 20, 12, 28, 8, 24, 5, 21, 13, 29, 1, 17, 9, 25, 3, 19, 11, 27, 7, 23, 15, 31.
- R9: Configuration inputs and `cfg_err` take effect only on a clock where `in_en` and `in_fs` are both high. After reset all ports are inactive and `cfg_err`, `drop_valid` and `out_en` are 0.
- R10: `in_en` with `in_fs` places the current bit at slot 0, bit 0. Without a marker the position advances once per enabled bit and wraps after 256 bits. Cycles with `in_en` low do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_en | input | 1 | Composite bit strobe |
| in_fs | input | 1 | Marks the first bit of a frame (qualified by in_en) |
| in_bit | input | 1 | Incoming composite bit |
| cfg_dflt | input | 1 | Use the fixed priority slot sequence |
| cfg_en | input | NPORTS | Per-port enable in explicit mode |
| cfg_slot | input | 5*NPORTS | Per-port slot number, port k at bits 5k+4..5k |
| ins_inhibit | input | NPORTS | Per-port insertion inhibit |
| ins_ais | input | NPORTS | Per-port all-ones alarm fill |
| trib_data | input | 8*NPORTS | Per-port tributary octet, port k at bits 8k+7..8k |
| out_en | output | 1 | Outgoing composite bit strobe |
| out_bit | output | 1 | Outgoing composite bit |
| drop_valid | output | NPORTS | Per-port dropped-octet strobe |
| drop_data | output | 8*NPORTS | Per-port dropped octet, port k at bits 8k+7..8k |
| cfg_err | output | NPORTS | Per-port refused-assignment flag |

## Verification
The bench aims at the slot-boundary cases. It flips `trib_data`, `ins_inhibit` and `ins_ais` on every bit, so a design that sampled them per bit rather than per slot would emit a torn mixture of two octets. Reserved slot numbers and duplicate claims are mixed into random configurations. A design that compared against refused ports, or let the higher index win, would drop from or write into the wrong slot and report the wrong `cfg_err`. Configuration inputs are also scrambled mid-frame to catch a design that applies them before the next frame marker. Frames without a marker and idle cycles between bits expose a counter that fails to wrap or advances on idle cycles.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

   localparam int SLOTS_PER_FRAME = 32;
   localparam int BITS_PER_SLOT   = 8;
   localparam int SLOT_W          = $clog2(SLOTS_PER_FRAME);
   localparam int BIT_W           = $clog2(BITS_PER_SLOT);
   localparam int POS_W           = SLOT_W + BIT_W;
   localparam int FRAME_SLOT      = 0;
   localparam int SIG_SLOT        = 16;
   localparam int MAX_PORTS       = SLOTS_PER_FRAME - 2;

   typedef logic [SLOT_W-1:0]        slot_t;
   typedef logic [BIT_W-1:0]         bitn_t;
   typedef logic [BITS_PER_SLOT-1:0] octet_t;

   // A slot can be owned by a port unless it carries framing or signalling.
   function automatic logic is_access(slot_t s);
      return (s != slot_t'(FRAME_SLOT)) && (s != slot_t'(SIG_SLOT));
   endfunction

   // Slot taken by port idx when ports are assigned in the fixed sequence.
   function automatic slot_t prio_slot(int idx);
      slot_t r;
      case (idx)
         0:  r = 5'd6;   1:  r = 5'd22;  2:  r = 5'd14;  3:  r = 5'd30;
         4:  r = 5'd2;   5:  r = 5'd18;  6:  r = 5'd10;  7:  r = 5'd26;
         8:  r = 5'd4;   9:  r = 5'd20;  10: r = 5'd12;  11: r = 5'd28;
         12: r = 5'd8;   13: r = 5'd24;  14: r = 5'd5;   15: r = 5'd21;
         16: r = 5'd13;  17: r = 5'd29;  18: r = 5'd1;   19: r = 5'd17;
         20: r = 5'd9;   21: r = 5'd25;  22: r = 5'd3;   23: r = 5'd19;
         24: r = 5'd11;  25: r = 5'd27;  26: r = 5'd7;   27: r = 5'd23;
         28: r = 5'd15;  29: r = 5'd31;
         default: r = 5'd0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tsx_slot_timer.sv
module tsx_slot_timer
   import tsx_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  in_en,
   input  logic  in_fs,
   output slot_t cur_slot,
   output bitn_t cur_bit
);

   logic [POS_W-1:0] cnt;
   logic [POS_W-1:0] pos;

   // A qualified frame marker forces the current bit to position zero.
   assign pos = (in_en && in_fs) ? '0 : cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (in_en) begin
         cnt <= pos + 1'b1;
      end
   end

   assign cur_slot = pos[POS_W-1:BIT_W];
   assign cur_bit  = pos[BIT_W-1:0];

endmodule

// File: rtl/tsx_port_cfg.sv
module tsx_port_cfg
   import tsx_pkg::*;
#(
   parameter int NPORTS = 4
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     cfg_dflt,
   input  logic [NPORTS-1:0]        cfg_en,
   input  logic [NPORTS*SLOT_W-1:0] cfg_slot,
   output logic [NPORTS-1:0]        act,
   output logic [NPORTS*SLOT_W-1:0] act_slot,
   output logic [NPORTS-1:0]        cfg_err
);

   logic [NPORTS-1:0] eff_en;
   logic [NPORTS-1:0] bad;
   slot_t             eff_slot [NPORTS];

   // Pick the requested slot per port, either from its field or the sequence.
   always_comb begin
      for (int p = 0; p < NPORTS; p++) begin
         eff_en[p]   = cfg_dflt | cfg_en[p];
         eff_slot[p] = cfg_dflt ? prio_slot(p) : cfg_slot[p*SLOT_W +: SLOT_W];
      end
   end

   // Refuse reserved slots, and any slot already claimed by a lower index.
   always_comb begin
      for (int p = 0; p < NPORTS; p++) begin
         bad[p] = eff_en[p] & ~is_access(eff_slot[p]);
         for (int q = 0; q < NPORTS; q++) begin
            if (q < p && eff_en[q] && eff_en[p] && eff_slot[q] == eff_slot[p]) begin
               bad[p] = 1'b1;
            end
         end
      end
   end

   // Shadow registers: a new assignment lands only on a frame marker.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act      <= '0;
         act_slot <= '0;
         cfg_err  <= '0;
      end else if (load) begin
         act     <= eff_en & ~bad;
         cfg_err <= bad;
         for (int p = 0; p < NPORTS; p++) begin
            act_slot[p*SLOT_W +: SLOT_W] <= eff_slot[p];
         end
      end
   end

endmodule

// File: rtl/tsx_lane.sv
module tsx_lane
   import tsx_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   act,
   input  slot_t  act_slot,
   input  slot_t  cur_slot,
   input  bitn_t  cur_bit,
   input  logic   in_en,
   input  logic   in_bit,
   input  octet_t trib,
   input  logic   inhibit,
   input  logic   ais,
   output logic   hit,
   output logic   ais_on,
   output logic   ovr,
   output logic   ovr_bit,
   output logic   drop_valid,
   output octet_t drop_data
);

   localparam bitn_t LAST_BIT = bitn_t'(BITS_PER_SLOT - 1);

   logic   first;
   octet_t hold_q;
   logic   inh_q;
   logic   ais_q;
   octet_t cur_hold;
   logic   cur_inh;
   logic   cur_ais;
   bitn_t  sel;
   octet_t dsh;

   assign hit   = act && in_en && (cur_slot == act_slot);
   assign first = hit && (cur_bit == '0);

   // Octet and controls are frozen for the slot at its first bit.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         inh_q  <= 1'b0;
         ais_q  <= 1'b0;
      end else if (first) begin
         hold_q <= trib;
         inh_q  <= inhibit;
         ais_q  <= ais;
      end
   end

   assign cur_hold = first ? trib    : hold_q;
   assign cur_inh  = first ? inhibit : inh_q;
   assign cur_ais  = first ? ais     : ais_q;
   assign sel      = LAST_BIT - cur_bit;

   assign ais_on  = hit && cur_ais;
   assign ovr     = hit && (cur_ais || !cur_inh);
   assign ovr_bit = cur_ais | cur_hold[sel];

   // Drop path: shift the slot in, publish the octet on its last bit.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dsh        <= '0;
         drop_data  <= '0;
         drop_valid <= 1'b0;
      end else begin
         drop_valid <= hit && (cur_bit == LAST_BIT);
         if (hit) begin
            dsh <= {dsh[BITS_PER_SLOT-2:0], in_bit};
         end
         if (hit && (cur_bit == LAST_BIT)) begin
            drop_data <= {dsh[BITS_PER_SLOT-2:0], in_bit};
         end
      end
   end

endmodule

// File: rtl/tsx_drop_insert.sv
module tsx_drop_insert
   import tsx_pkg::*;
#(
   parameter int NPORTS = 4
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_en,
   input  logic                            in_fs,
   input  logic                            in_bit,
   input  logic                            cfg_dflt,
   input  logic [NPORTS-1:0]               cfg_en,
   input  logic [NPORTS*SLOT_W-1:0]        cfg_slot,
   input  logic [NPORTS-1:0]               ins_inhibit,
   input  logic [NPORTS-1:0]               ins_ais,
   input  logic [NPORTS*BITS_PER_SLOT-1:0] trib_data,
   output logic                            out_en,
   output logic                            out_bit,
   output logic [NPORTS-1:0]               drop_valid,
   output logic [NPORTS*BITS_PER_SLOT-1:0] drop_data,
   output logic [NPORTS-1:0]               cfg_err
);

   if (NPORTS < 1 || NPORTS > MAX_PORTS) begin : g_bad_nports
      $error("tsx_drop_insert: NPORTS must lie in 1..%0d", MAX_PORTS);
   end
   if (SLOTS_PER_FRAME != (1 << SLOT_W)) begin : g_bad_slots
      $error("tsx_drop_insert: slot count must be a power of two");
   end
   if (BITS_PER_SLOT != (1 << BIT_W)) begin : g_bad_bits
      $error("tsx_drop_insert: slot width must be a power of two");
   end

   slot_t                    cur_slot;
   bitn_t                    cur_bit;
   logic [NPORTS-1:0]        act;
   logic [NPORTS*SLOT_W-1:0] act_slot;
   logic [NPORTS-1:0]        lane_hit;
   logic [NPORTS-1:0]        lane_ais;
   logic [NPORTS-1:0]        lane_ovr;
   logic [NPORTS-1:0]        lane_obit;
   logic                     ovr_any;
   logic                     ovr_val;

   tsx_slot_timer u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_en    (in_en),
      .in_fs    (in_fs),
      .cur_slot (cur_slot),
      .cur_bit  (cur_bit)
   );

   tsx_port_cfg #(.NPORTS(NPORTS)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (in_en && in_fs),
      .cfg_dflt (cfg_dflt),
      .cfg_en   (cfg_en),
      .cfg_slot (cfg_slot),
      .act      (act),
      .act_slot (act_slot),
      .cfg_err  (cfg_err)
   );

   for (genvar p = 0; p < NPORTS; p++) begin : g_lane
      tsx_lane u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .act        (act[p]),
         .act_slot   (act_slot[p*SLOT_W +: SLOT_W]),
         .cur_slot   (cur_slot),
         .cur_bit    (cur_bit),
         .in_en      (in_en),
         .in_bit     (in_bit),
         .trib       (trib_data[p*BITS_PER_SLOT +: BITS_PER_SLOT]),
         .inhibit    (ins_inhibit[p]),
         .ais        (ins_ais[p]),
         .hit        (lane_hit[p]),
         .ais_on     (lane_ais[p]),
         .ovr        (lane_ovr[p]),
         .ovr_bit    (lane_obit[p]),
         .drop_valid (drop_valid[p]),
         .drop_data  (drop_data[p*BITS_PER_SLOT +: BITS_PER_SLOT])
      );
   end

   // Owned slots are unique, so at most one lane overrides a given bit.
   assign ovr_any = |lane_ovr;
   assign ovr_val = |(lane_ovr & lane_obit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_en  <= 1'b0;
         out_bit <= 1'b0;
      end else begin
         out_en  <= in_en;
         out_bit <= ovr_any ? ovr_val : in_bit;
      end
   end

endmodule

// File: rtl/tsx_drop_insert_chk.sv
module tsx_drop_insert_chk
   import tsx_pkg::*;
#(
   parameter int NPORTS = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_en,
   input logic              in_fs,
   input logic              in_bit,
   input logic              out_en,
   input logic              out_bit,
   input slot_t             cur_slot,
   input logic [NPORTS-1:0] lane_hit,
   input logic [NPORTS-1:0] lane_ais,
   input logic [NPORTS-1:0] drop_valid,
   input logic [NPORTS-1:0] cfg_err
);

   assert_out_en_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_en |=> out_en);

   assert_out_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_en |=> !out_en);

   assert_frame_slot_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_en && cur_slot == slot_t'(FRAME_SLOT)) |=> (out_bit == $past(in_bit)));

   assert_single_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_hit));

   assert_ais_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_ais) |=> out_bit);

   assert_err_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_en && in_fs) |=> $stable(cfg_err));

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      assert_drop_after_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
         drop_valid[p] |-> $past(lane_hit[p]));
   end

endmodule

bind tsx_drop_insert tsx_drop_insert_chk #(.NPORTS(NPORTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_en      (in_en),
   .in_fs      (in_fs),
   .in_bit     (in_bit),
   .out_en     (out_en),
   .out_bit    (out_bit),
   .cur_slot   (cur_slot),
   .lane_hit   (lane_hit),
   .lane_ais   (lane_ais),
   .drop_valid (drop_valid),
   .cfg_err    (cfg_err)
);

// File: tb/tsx_drop_insert_test.sv
module tsx_drop_insert_test;

   localparam int NP = 4;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            in_en, in_fs, in_bit, cfg_dflt;
   logic [NP-1:0]   cfg_en, ins_inhibit, ins_ais;
   logic [NP*5-1:0] cfg_slot;
   logic [NP*8-1:0] trib_data;
   logic            out_en, out_bit;
   logic [NP-1:0]   drop_valid, cfg_err;
   logic [NP*8-1:0] drop_data;

   always #4 clk = ~clk;

   tsx_drop_insert #(.NPORTS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_fs(in_fs), .in_bit(in_bit),
      .cfg_dflt(cfg_dflt), .cfg_en(cfg_en), .cfg_slot(cfg_slot),
      .ins_inhibit(ins_inhibit), .ins_ais(ins_ais), .trib_data(trib_data),
      .out_en(out_en), .out_bit(out_bit), .drop_valid(drop_valid),
      .drop_data(drop_data), .cfg_err(cfg_err)
   );

   int n_vec = 0;
   int n_bad = 0;

   int PRI [30] = '{6, 22, 14, 30, 2, 18, 10, 26, 4, 20, 12, 28, 8, 24, 5,
                    21, 13, 29, 1, 17, 9, 25, 3, 19, 11, 27, 7, 23, 15, 31};

   // Reference model state
   int       mcnt;
   bit       m_act [NP];
   int       m_slot [NP];
   bit       m_err [NP];
   string    m_why [NP];
   bit [7:0] mhold [NP];
   bit       minh [NP];
   bit       mais [NP];
   bit [7:0] mdsh [NP];
   bit [7:0] m_dd [NP];
   string    ph = "";

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_set(int p, int s, bit e);
      cfg_slot[p*5 +: 5] = 5'(s);
      cfg_en[p] = e;
   endtask

   // Recompute accepted assignments from the configuration inputs (R6 R7 R8).
   task automatic recompute();
      bit en_v [NP];
      int s_v [NP];
      for (int p = 0; p < NP; p++) begin
         en_v[p] = cfg_dflt || cfg_en[p];
         s_v[p]  = cfg_dflt ? PRI[p] : int'(cfg_slot[p*5 +: 5]);
      end
      for (int p = 0; p < NP; p++) begin
         bit bad = 0;
         m_why[p] = cfg_dflt ? "R8" : "R9";
         if (en_v[p] && (s_v[p] == 0 || s_v[p] == 16)) begin
            bad = 1; m_why[p] = "R6";
         end
         for (int q = 0; q < p; q++) begin
            if (en_v[p] && en_v[q] && s_v[q] == s_v[p] && !bad) begin
               bad = 1; m_why[p] = "R7";
            end
         end
         m_err[p]  = bad;
         m_act[p]  = en_v[p] && !bad;
         m_slot[p] = s_v[p];
      end
   endtask

   task automatic step(bit en, bit fs);
      bit    b = 1'($urandom);
      int    pos, slot, bn;
      bit    exp_bit;
      string tag = "R1";
      bit    dv [NP];
      for (int p = 0; p < NP; p++) begin
         trib_data[p*8 +: 8] = 8'($urandom);
         ins_ais[p]     = ($urandom % 6 == 0);
         ins_inhibit[p] = ($urandom % 4 == 0);
         dv[p] = 0;
      end
      in_en = en; in_fs = fs; in_bit = b;
      pos  = (en && fs) ? 0 : mcnt;
      slot = pos / 8;
      bn   = pos % 8;
      exp_bit = b;
      for (int p = 0; p < NP; p++) begin
         if (en && m_act[p] && m_slot[p] == slot) begin
            if (bn == 0) begin
               mhold[p] = trib_data[p*8 +: 8];
               minh[p]  = ins_inhibit[p];
               mais[p]  = ins_ais[p];
            end
            if (mais[p]) begin
               exp_bit = 1; tag = "R5";
            end else if (!minh[p]) begin
               exp_bit = mhold[p][7-bn]; tag = "R3";
            end else begin
               tag = "R4";
            end
            mdsh[p] = {mdsh[p][6:0], b};
            if (bn == 7) begin
               dv[p] = 1; m_dd[p] = mdsh[p];
            end
         end
      end
      if (en && fs) recompute();
      if (en) mcnt = (pos + 1) % 256;
      if (ph != "") tag = ph;
      @(posedge clk);
      @(negedge clk);
      chk(out_en == en, "R1", "out_en", int'(out_en), int'(en));
      if (en) chk(out_bit == exp_bit, tag, "out_bit", int'(out_bit), int'(exp_bit));
      for (int p = 0; p < NP; p++) begin
         string dt = m_err[p] ? "R6" : (ph != "" ? ph : "R2");
         chk(drop_valid[p] == dv[p], dt, $sformatf("drop_valid[%0d]", p),
             int'(drop_valid[p]), int'(dv[p]));
         if (dv[p]) chk(drop_data[p*8 +: 8] == m_dd[p], dt, $sformatf("drop_data[%0d]", p),
                        int'(drop_data[p*8 +: 8]), int'(m_dd[p]));
         chk(cfg_err[p] == m_err[p], m_why[p], $sformatf("cfg_err[%0d]", p),
             int'(cfg_err[p]), int'(m_err[p]));
      end
   endtask

   task automatic frame(bit with_fs, bit scramble);
      for (int i = 0; i < 256; i++) begin
         if ($urandom % 10 == 0) step(0, 0);
         step(1, (i == 0) && with_fs);
         if (scramble && i == 128) begin
            cfg_dflt = ($urandom % 3 == 0);
            for (int p = 0; p < NP; p++) cfg_set(p, $urandom % 32, 1'($urandom));
         end
      end
   endtask

   task automatic set_a();
      cfg_dflt = 0;
      cfg_set(0, 3, 1); cfg_set(1, 17, 1); cfg_set(2, 31, 1); cfg_set(3, 1, 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_E1E1));
      rst_n = 0; in_en = 0; in_fs = 0; in_bit = 0; cfg_dflt = 0;
      cfg_en = '0; cfg_slot = '0; ins_inhibit = '0; ins_ais = '0; trib_data = '0;
      mcnt = 0;
      for (int p = 0; p < NP; p++) begin
         m_act[p] = 0; m_err[p] = 0; m_slot[p] = 0; m_why[p] = "R9";
         mhold[p] = 0; minh[p] = 0; mais[p] = 0; mdsh[p] = 0; m_dd[p] = 0;
      end
      repeat (4) begin
         @(negedge clk);
         // R9: reset state
         chk(out_en == 0, "R9", "out_en in reset", int'(out_en), 0);
         chk(drop_valid == '0, "R9", "drop_valid in reset", int'(drop_valid), 0);
         chk(cfg_err == '0, "R9", "cfg_err in reset", int'(cfg_err), 0);
      end
      rst_n = 1;

      // Directed: legal explicit assignment
      set_a();
      repeat (30) frame(1, 0);

      // Directed: reserved slots (R6) and duplicate claim (R7)
      cfg_dflt = 0;
      cfg_set(0, 16, 1); cfg_set(1, 5, 1); cfg_set(2, 0, 1); cfg_set(3, 5, 1);
      repeat (15) frame(1, 0);

      // Disabled port on a reserved slot raises no flag; duplicate of a lower port
      cfg_set(0, 9, 1); cfg_set(1, 16, 0); cfg_set(2, 9, 1); cfg_set(3, 25, 1);
      repeat (10) frame(1, 0);

      // R8: fixed priority sequence, junk in the explicit fields
      cfg_dflt = 1;
      cfg_set(0, 0, 0); cfg_set(1, 16, 0); cfg_set(2, 3, 1); cfg_set(3, 3, 1);
      ph = "R8";
      repeat (15) frame(1, 0);
      ph = "";

      // R10: counter wraps without markers
      set_a();
      frame(1, 0);
      ph = "R10";
      repeat (3) frame(0, 0);
      ph = "";

      // Random configurations, scrambled mid-frame (R9)
      repeat (130) begin
         cfg_dflt = ($urandom % 8 == 0);
         for (int p = 0; p < NP; p++) begin
            int s = ($urandom % 4 == 0) ? (($urandom % 2) ? 0 : 16) : ($urandom % 32);
            cfg_set(p, s, ($urandom % 5 != 0));
         end
         frame(1, 1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule